// File: doc/BRIEF.md
# Split-Access 64-bit Register Bank

This block is a slave register bank on a 32-bit word-addressed access port. It holds 64-bit registers: one machine configuration register and seven 64-bit event counters. Each 64-bit register takes up two adjacent word addresses. The even word carries bits 63:32 and the odd word carries bits 31:0. Software builds a 64-bit write from two word writes. The even word waits in a staging register, and the odd word commits both halves together.

On the read side, the bank returns a 64-bit counter consistently over two 32-bit cycles. Reading the even word captures the odd half at the same instant, and the following read of the odd word returns that captured copy even if the counter moved in between.

The configuration register also carries a self-clearing software-reset bit, which drives a one-cycle pulse output. Event strobes advance the counters. Request counters count strobes, and byte counters add a supplied byte count.

Top module: `split64_regbank`

## Requirements
- R1: Slot s (64-bit register s) sits at word address 2s (bits 63:32) and 2s+1 (bits 31:0). Slot 0 is the configuration register and slots 1..7 are the counters.
- R2: A write to an even word of a mapped slot only loads the staging register. The addressed 64-bit register keeps its value until the odd word is written.
- R3: A write to the odd word of a mapped slot commits {staged word, written word} in one cycle, and the staging register then reads as zero. An odd-word write with no preceding even write therefore commits zero into bits 63:32.
- R4: bus_rdata is registered. It shows the result of a read in the cycle after bus_rd and holds until the next read. It is zero after reset.
- R5: A read of an even word returns the live bits 63:32 and captures the live bits 31:0 at the same clock edge. If the next access is a read of the odd word of the same slot, that read returns the captured value.
- R6: Any other access between the two halves clears the capture: a write, a read of another address, or an unmapped read. An odd-word read then returns the live bits 31:0.
- R7: In the configuration register only these bits of word 1 are stored: 31 soft reset, 30 watchdog enable, 29 watchdog force-fail, 28 DMA reset, 16 long pointers, 15:12 read cache, 11:8 write cache, 7:4 pipeline depth, 3 priority sideband, 0 burst select (mask 0xF001FFF9). All other bits, and the whole of word 0, read as zero.
- R8: Committing bit 31 of the configuration register raises sw_reset_pulse for exactly the cycle after the commit edge. The bit then clears by itself.
- R9: evt_strobe bit k advances counter slot k+1. The counters are, in order: dequeued requests, outbound encrypt requests, inbound decrypt requests, outbound bytes encrypted, outbound bytes protected, inbound bytes decrypted, inbound bytes validated. The first three add 1 per strobe cycle and the last four add evt_bytes.
- R10: Counters wrap modulo 2^64, and a carry from bits 31:0 propagates into bits 63:32.
- R11: A commit to a counter in the same cycle as its strobe loads the committed value, and the event is dropped.
- R12: Reads of unmapped words (slot 8 and above) return zero. Writes to them change neither any register nor the staging register.
- R13: When bus_wr and bus_rd are both high, only the write is performed and bus_rdata is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_strobe | input | N_CNT | Per-counter event strobes |
| evt_bytes | input | BYTE_W | Byte count added by byte counters |
| sw_reset_pulse | output | 1 | One-cycle software reset pulse |

## Verification
The bench strobes a counter on every cycle between the two halves of a read, so a design that returned the live lower word would show a torn value. It puts a write or a different read between the halves to catch a capture that survives when it should be cleared. It commits an odd word alone and places an unmapped write between the two halves of a write. A design that kept the staged word or staged on unmapped addresses would then load the wrong upper half. A counter is also driven through a 32-bit carry and past 2^64, and a commit lands in the same cycle as a strobe, where a design giving the event priority would be off by the increment.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;

    localparam int WORD_W  = 32;
    localparam int DWORD_W = 64;

    // bits of the configuration word that are actually stored
    localparam logic [WORD_W-1:0] CFG_KEEP_MASK = 32'hF001_FFF9;

    typedef enum logic {
        HALF_UPPER = 1'b0,   // even word: bits 63:32
        HALF_LOWER = 1'b1    // odd word:  bits 31:0
    } half_e;

    typedef struct packed {
        logic       soft_rst;
        logic       wdog_en;
        logic       wdog_fail;
        logic       dma_rst;
        logic [10:0] rsvd_hi;
        logic       long_ptr;
        logic [3:0] rd_cache;
        logic [3:0] wr_cache;
        logic [3:0] pipe_depth;
        logic       prio_side;
        logic [1:0] rsvd_lo;
        logic       burst_sel;
    } cfg_t;

    typedef struct packed {
        logic               valid;
        logic [DWORD_W-1:0] data;
    } commit_t;

    function automatic cfg_t cfg_pack(input logic [WORD_W-1:0] w);
        cfg_t c;
        c = cfg_t'(w & CFG_KEEP_MASK);
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] upper_of(input logic [DWORD_W-1:0] v);
        return v[DWORD_W-1:WORD_W];
    endfunction

    function automatic logic [WORD_W-1:0] lower_of(input logic [DWORD_W-1:0] v);
        return v[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/regbank_stage.sv
`timescale 1ns/1ps
module regbank_stage
    import regbank_pkg::*;
#(
    parameter int SLOT_W = 4,
    parameter int N_SLOT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [SLOT_W:0]     addr,
    input  logic [WORD_W-1:0]   wdata,
    output commit_t             commit,
    output logic [SLOT_W-1:0]   commit_slot
);

    logic [WORD_W-1:0] staged;
    logic [SLOT_W-1:0] slot;
    half_e             half;
    logic              mapped;

    assign slot   = addr[SLOT_W:1];
    assign half   = half_e'(addr[0]);
    assign mapped = int'(slot) < N_SLOT;

    assign commit.valid = wr && mapped && (half == HALF_LOWER);
    assign commit.data  = {staged, wdata};
    assign commit_slot  = slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
        end else if (wr && mapped) begin
            if (half == HALF_UPPER) staged <= wdata;
            else                    staged <= '0;
        end
    end

    AST_STAGE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        commit.valid |=> (staged == '0)); // R3
    AST_UNMAPPED_NO_STAGE: assert property (@(posedge clk) disable iff (rst)
        (wr && !mapped) |=> $stable(staged)); // R12

endmodule

// File: rtl/regbank_counter.sv
`timescale 1ns/1ps
module regbank_counter
    import regbank_pkg::*;
#(
    parameter int BYTE_W   = 16,
    parameter bit IS_BYTES = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [DWORD_W-1:0]  load_val,
    input  logic                evt,
    input  logic [BYTE_W-1:0]   evt_bytes,
    output logic [DWORD_W-1:0]  value
);

    logic [DWORD_W-1:0] step;

    generate
        if (IS_BYTES) begin : g_bytes
            assign step = DWORD_W'(evt_bytes);
        end else begin : g_reqs
            assign step = DWORD_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (load) value <= load_val;
        else if (evt)  value <= value + step;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !evt) |=> $stable(value)); // R9
    AST_CNT_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (load && evt) |=> (value == $past(load_val))); // R11

endmodule

// File: rtl/regbank_cfg.sv
`timescale 1ns/1ps
module regbank_cfg
    import regbank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [DWORD_W-1:0]  load_val,
    output logic [DWORD_W-1:0]  value,
    output logic                sw_reset_pulse
);

    cfg_t cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (load) begin
            cfg <= cfg_pack(lower_of(load_val));
        end else if (cfg.soft_rst) begin
            cfg.soft_rst <= 1'b0;
        end
    end

    assign value          = {{WORD_W{1'b0}}, cfg};
    assign sw_reset_pulse = cfg.soft_rst;

    AST_SWRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cfg.soft_rst && !load) |=> !cfg.soft_rst); // R8
    AST_CFG_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        load |=> (cfg.rsvd_hi == '0 && cfg.rsvd_lo == '0)); // R7

endmodule

// File: rtl/regbank_rdport.sv
`timescale 1ns/1ps
module regbank_rdport
    import regbank_pkg::*;
#(
    parameter int SLOT_W = 4,
    parameter int N_SLOT = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rd,
    input  logic                            wr,
    input  logic [SLOT_W:0]                 addr,
    input  logic [N_SLOT-1:0][DWORD_W-1:0]  slot_vals,
    output logic [WORD_W-1:0]               rdata
);

    localparam int IDX_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

    logic [SLOT_W-1:0]  slot;
    half_e              half;
    logic               mapped;
    logic [DWORD_W-1:0] live;
    logic [WORD_W-1:0]  cap_word;
    logic [SLOT_W-1:0]  cap_slot;
    logic               cap_valid;

    assign slot   = addr[SLOT_W:1];
    assign half   = half_e'(addr[0]);
    assign mapped = int'(slot) < N_SLOT;
    assign live   = mapped ? slot_vals[slot[IDX_W-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= '0;
            cap_word  <= '0;
            cap_slot  <= '0;
            cap_valid <= 1'b0;
        end else if (wr) begin
            cap_valid <= 1'b0;
        end else if (rd) begin
            if (!mapped) begin
                rdata     <= '0;
                cap_valid <= 1'b0;
            end else if (half == HALF_UPPER) begin
                rdata     <= upper_of(live);
                cap_word  <= lower_of(live);
                cap_slot  <= slot;
                cap_valid <= 1'b1;
            end else begin
                rdata     <= (cap_valid && cap_slot == slot) ? cap_word : lower_of(live);
                cap_valid <= 1'b0;
            end
        end
    end

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr && !mapped) |=> (rdata == '0)); // R12
    AST_CAPTURE_ARMED: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr && mapped && half == HALF_UPPER) |=> cap_valid); // R5
    AST_WRITE_DROPS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        wr |=> !cap_valid); // R6
    AST_WRITE_BLOCKS_READ: assert property (@(posedge clk) disable iff (rst)
        wr |=> $stable(rdata)); // R13

endmodule

// File: rtl/split64_regbank.sv
`timescale 1ns/1ps
module split64_regbank
    import regbank_pkg::*;
#(
    parameter int             ADDR_W        = 5,
    parameter int             N_CNT         = 7,
    parameter int             BYTE_W        = 16,
    parameter logic [N_CNT-1:0] BYTE_CNT_MASK = 7'b111_1000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [N_CNT-1:0]    evt_strobe,
    input  logic [BYTE_W-1:0]   evt_bytes,
    output logic                sw_reset_pulse
);

    localparam int SLOT_W = ADDR_W - 1;
    localparam int N_SLOT = N_CNT + 1;

    commit_t                        commit;
    logic [SLOT_W-1:0]              commit_slot;
    logic [N_SLOT-1:0][DWORD_W-1:0] slot_vals;
    logic                           cfg_load;

    regbank_stage #(.SLOT_W(SLOT_W), .N_SLOT(N_SLOT)) i_stage (
        .clk         (clk),
        .rst         (rst),
        .wr          (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .commit      (commit),
        .commit_slot (commit_slot)
    );

    assign cfg_load = commit.valid && (commit_slot == '0);

    regbank_cfg i_cfg (
        .clk            (clk),
        .rst            (rst),
        .load           (cfg_load),
        .load_val       (commit.data),
        .value          (slot_vals[0]),
        .sw_reset_pulse (sw_reset_pulse)
    );

    generate
        for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
            logic hit;
            assign hit = commit.valid && (commit_slot == SLOT_W'(k + 1));
            regbank_counter #(.BYTE_W(BYTE_W), .IS_BYTES(BYTE_CNT_MASK[k])) i_cnt (
                .clk       (clk),
                .rst       (rst),
                .load      (hit),
                .load_val  (commit.data),
                .evt       (evt_strobe[k]),
                .evt_bytes (evt_bytes),
                .value     (slot_vals[k + 1])
            );
        end
    endgenerate

    regbank_rdport #(.SLOT_W(SLOT_W), .N_SLOT(N_SLOT)) i_rdport (
        .clk       (clk),
        .rst       (rst),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .slot_vals (slot_vals),
        .rdata     (bus_rdata)
    );

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        sw_reset_pulse |-> $past(bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[31])); // R8
    AST_UPPER_STAGED_ONLY: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr[0] && evt_strobe == '0) |=> $stable(slot_vals[N_SLOT-1:1])); // R2

endmodule

// File: tb/test_split64_regbank.sv
`timescale 1ns/1ps
module test_split64_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  evt_strobe = '0;
    logic [15:0] evt_bytes = '0;
    logic        sw_reset_pulse;

    always #2 clk = ~clk;

    split64_regbank i_split64_regbank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_strobe(evt_strobe), .evt_bytes(evt_bytes),
        .sw_reset_pulse(sw_reset_pulse)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    logic [63:0] m_reg [8];
    logic [31:0] m_stage, m_cap, m_rdata;
    logic        m_capv;
    int          m_capslot;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic wr, input logic rd, input logic [4:0] addr,
                         input logic [31:0] wd, input logic [6:0] strb, input logic [15:0] bytes);
        int slot;
        bit upper, mapped;
        logic [63:0] old [8];
        logic [63:0] v;
        slot   = int'(addr) / 2;
        upper  = (addr[0] == 1'b0);
        mapped = slot < 8;
        for (int i = 0; i < 8; i++) old[i] = m_reg[i];
        if (rd && !wr) begin
            if (!mapped) begin
                m_rdata = 0; m_capv = 0;
            end else if (upper) begin
                m_rdata = old[slot][63:32]; m_cap = old[slot][31:0];
                m_capv = 1; m_capslot = slot;
            end else begin
                m_rdata = (m_capv && m_capslot == slot) ? m_cap : old[slot][31:0];
                m_capv = 0;
            end
        end else if (wr) begin
            m_capv = 0;
        end
        if (old[0][31]) m_reg[0][31] = 1'b0;
        for (int k = 0; k < 7; k++)
            if (strb[k]) m_reg[k + 1] = m_reg[k + 1] + ((k >= 3) ? 64'(bytes) : 64'd1);
        if (wr && mapped) begin
            if (upper) m_stage = wd;
            else begin
                v = {m_stage, wd};
                if (slot == 0) v = v & 64'h0000_0000_F001_FFF9;
                m_reg[slot] = v;
                m_stage = 0;
            end
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic [4:0] addr, input logic [31:0] wd,
                        input logic [6:0] strb, input logic [15:0] bytes, input string tag);
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wd;
        evt_strobe = strb; evt_bytes = bytes;
        @(posedge clk);
        model(wr, rd, addr, wd, strb, bytes);
        @(negedge clk);
        check(bus_rdata == m_rdata, tag, 64'(bus_rdata), 64'(m_rdata));
        check(sw_reset_pulse == m_reg[0][31], {tag, " pulse"}, 64'(sw_reset_pulse), 64'(m_reg[0][31]));
    endtask

    task automatic wr64(input int slot, input logic [63:0] v, input string tag);
        step(1, 0, 5'(2 * slot), v[63:32], '0, '0, tag);
        step(1, 0, 5'(2 * slot + 1), v[31:0], '0, '0, tag);
    endtask

    task automatic rd64(input int slot, input string tag, output logic [63:0] got);
        step(0, 1, 5'(2 * slot), '0, '0, '0, tag);
        got[63:32] = bus_rdata;
        step(0, 1, 5'(2 * slot + 1), '0, '0, '0, tag);
        got[31:0] = bus_rdata;
    endtask

    task automatic idle(input int n, input logic [6:0] strb, input logic [15:0] bytes, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, '0, '0, strb, bytes, tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] got;
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_stage = 0; m_cap = 0; m_rdata = 0; m_capv = 0; m_capslot = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(bus_rdata == 0, "R4 reset rdata", 64'(bus_rdata), 0);
        check(sw_reset_pulse == 0, "R8 reset pulse", 64'(sw_reset_pulse), 0);

        // R1 R3: full write then read back each half
        wr64(2, 64'h1122_3344_5566_7788, "R3 commit");
        rd64(2, "R1 layout", got);
        check(got == 64'h1122_3344_5566_7788, "R1 readback", got, 64'h1122_3344_5566_7788);

        // R2: staged upper does not touch register
        step(1, 0, 5'd4, 32'hDEAD_BEEF, '0, '0, "R2 stage");
        rd64(2, "R2 no effect", got);
        check(got == 64'h1122_3344_5566_7788, "R2 unchanged", got, 64'h1122_3344_5566_7788);
        // the read in between does not clear staging; commit now
        step(1, 0, 5'd5, 32'h0000_0001, '0, '0, "R3 late commit");
        rd64(2, "R3 late", got);
        check(got == 64'hDEAD_BEEF_0000_0001, "R3 staged upper", got, 64'hDEAD_BEEF_0000_0001);
        // odd-only write commits upper zero
        step(1, 0, 5'd5, 32'h0000_00AA, '0, '0, "R3 odd only");
        rd64(2, "R3 odd only rd", got);
        check(got == 64'h0000_0000_0000_00AA, "R3 zero upper", got, 64'hAA);

        // R12: unmapped write between halves leaves stage alone
        step(1, 0, 5'd6, 32'h0000_0077, '0, '0, "R12 stage");
        step(1, 0, 5'd20, 32'hFFFF_FFFF, '0, '0, "R12 unmapped wr");
        step(1, 0, 5'd21, 32'hFFFF_FFFF, '0, '0, "R12 unmapped wr");
        step(1, 0, 5'd7, 32'h0000_0001, '0, '0, "R12 commit");
        rd64(3, "R12 rd", got);
        check(got == 64'h0000_0077_0000_0001, "R12 stage kept", got, 64'h0000_0077_0000_0001);
        step(0, 1, 5'd18, '0, '0, '0, "R12 unmapped read");
        step(0, 1, 5'd31, '0, '0, '0, "R12 unmapped read");

        // R9 R10: carry across 32 bits on request counter slot 1
        wr64(1, 64'h0000_0000_FFFF_FFFF, "R10 load");
        idle(1, 7'b000_0001, '0, "R10 carry");
        rd64(1, "R10 rd", got);
        check(got == 64'h0000_0001_0000_0000, "R10 carry", got, 64'h1_0000_0000);

        // R10: wrap on byte counter slot 4
        wr64(4, 64'hFFFF_FFFF_FFFF_FFF0, "R10 load wrap");
        idle(1, 7'b000_1000, 16'h0020, "R10 wrap");
        rd64(4, "R10 wrap rd", got);
        check(got == 64'h10, "R10 wrap", got, 64'h10);

        // R9: all counters strobing with varied byte counts
        for (int i = 0; i < 20; i++) idle(1, 7'(i * 37 + 5), 16'(i * 911 + 3), "R9 events");
        for (int s = 1; s < 8; s++) rd64(s, "R9 counter read", got);

        // R5: coherent read while counter moves every cycle
        wr64(5, 64'h0000_0003_FFFF_FF00, "R5 load");
        step(0, 1, 5'd10, '0, 7'b001_0000, 16'h0200, "R5 upper");
        step(0, 0, 5'd0, '0, 7'b001_0000, 16'h0200, "R5 gap");
        step(0, 1, 5'd11, '0, 7'b001_0000, 16'h0200, "R5 lower");
        check(bus_rdata == 32'hFFFF_FF00, "R5 captured", 64'(bus_rdata), 64'hFFFF_FF00);

        // R6: write between halves clears capture
        step(0, 1, 5'd10, '0, 7'b001_0000, 16'h0010, "R6 upper");
        step(1, 0, 5'd20, 32'h1, 7'b001_0000, 16'h0010, "R6 intervening wr");
        step(0, 1, 5'd11, '0, 7'b001_0000, 16'h0010, "R6 live lower");
        // read of another slot between halves
        step(0, 1, 5'd2, '0, 7'b000_0001, '0, "R6 upper");
        step(0, 1, 5'd13, '0, 7'b000_0001, '0, "R6 other read");
        step(0, 1, 5'd3, '0, 7'b000_0001, '0, "R6 live lower");

        // R11: commit and strobe in same cycle
        step(1, 0, 5'd12, 32'h0000_0005, '0, '0, "R11 stage");
        step(1, 0, 5'd13, 32'h0000_0009, 7'b010_0000, 16'h0100, "R11 commit+evt");
        rd64(6, "R11 rd", got);
        check(got == 64'h0000_0005_0000_0009, "R11 load wins", got, 64'h5_0000_0009);

        // R7: configuration mask
        wr64(0, 64'hFFFF_FFFF_7FFF_FFFF, "R7 cfg write");
        rd64(0, "R7 cfg rd", got);
        check(got == 64'h0000_0000_7001_FFF9, "R7 mask", got, 64'h7001_FFF9);

        // R8: software reset by odd word alone, pulse one cycle
        step(1, 0, 5'd1, 32'h8000_0000, '0, '0, "R8 trigger");
        check(sw_reset_pulse == 1'b1, "R8 pulse high", 64'(sw_reset_pulse), 1);
        idle(1, '0, '0, "R8 pulse low");
        check(sw_reset_pulse == 1'b0, "R8 pulse cleared", 64'(sw_reset_pulse), 0);
        rd64(0, "R8 rd", got);
        check(got == 64'h0, "R8 bit cleared", got, 0);

        // R13: write and read together
        step(0, 1, 5'd4, '0, '0, '0, "R13 prior read");
        step(1, 1, 5'd5, 32'h0000_0042, '0, '0, "R13 wr wins");
        rd64(2, "R13 rd", got);
        check(got == 64'h42, "R13 write done", got, 64'h42);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule